// File: doc/BRIEF.md
# Inter-Core Response Mailbox Register

This block is an 8-bit status register that two processor cores share. The slave core uses it to report a response to the master: a 4-bit status code and a data-valid flag. The master core reads the register and acknowledges the response by clearing the flag. The slave core also holds a request-interrupt enable bit here. That bit gates the interrupt the slave receives when the master posts a new request.

A hardware watchdog path watches the slave's watchdog count. When the count is all ones, the hardware forces a status code of zero and sets the data-valid flag. It then locks the status field and the flag against software until the slave core is reset. The lock is released only by the slave-core reset strobe or by the global asynchronous reset. Both of these return the register to zero.

Top module: `mbx_rsp_reg`

## Requirements
- R1: After reset the register reads 0x00 on both read ports. Bits 7:6 always read 0. Layout: status in bits 3:0, interrupt enable in bit 4, data-valid in bit 5.
- R2: A slave write loads bits 3:0 (status) and bit 4 (enable) from the write data when no lock is active.
- R3: A slave write with bit 5 set sets the data-valid flag.
- R4: A master write with bit 5 clear clears the data-valid flag. Every other master write bit is ignored, and a master write with bit 5 set has no effect.
- R5: A slave write never clears the data-valid flag. Only a master clear or a reset clears it.
- R6: If a master clear and a slave set arrive in the same cycle, the flag ends up set.
- R7: A watchdog count of 0xFFFF loads status 0000 and sets the flag one cycle later. A count of 0xFFFE does nothing. The enable bit still follows a slave write made in the same cycle.
- R8: While locked, slave writes leave the status unchanged and master clears leave the flag set. Slave writes still update the enable bit.
- R9: The lock persists until the slave-core reset strobe. That strobe clears the lock and returns the register to 0x00, and it overrides any write in the same cycle.
- R10: The request interrupt equals the master request-valid input while the enable bit is 1, and is 0 while the enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slv_rst_i | input | 1 | Synchronous slave-core reset strobe |
| slv_we_i | input | 1 | Slave write strobe |
| slv_wdata_i | input | 8 | Slave write data |
| slv_rdata_o | output | 8 | Slave read data |
| mst_we_i | input | 1 | Master write strobe |
| mst_wdata_i | input | 8 | Master write data (only bit 5 used) |
| mst_rdata_o | output | 8 | Master read data |
| wdt_cnt_i | input | 16 | Slave watchdog count |
| mreq_dv_i | input | 1 | Master request-valid flag |
| req_irq_o | output | 1 | Request interrupt to the slave |

## Verification
Most internal faults in the stored fields appear on both read ports in the cycle after the write that exposes them. A hidden lock flag is different: it shows nothing until the next status write or master clear is silently dropped. The bench therefore follows every watchdog event with a write and a clear. It also checks the release, because a lock that is stuck set only shows after the slave reset. An enable fault shows at once on the interrupt pin when the request input toggles.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned STAT_W = 4;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned IEN_POS = STAT_W;
  localparam int unsigned DV_POS  = STAT_W + 1;

  typedef struct packed {
    logic              dv;
    logic              ien;
    logic [STAT_W-1:0] stat;
  } rsp_fields_t;

  function automatic logic [REG_W-1:0] pack_rsp(rsp_fields_t f);
    logic [REG_W-1:0] r;
    r = '0;
    r[STAT_W-1:0] = f.stat;
    r[IEN_POS]    = f.ien;
    r[DV_POS]     = f.dv;
    return r;
  endfunction
endpackage

// File: rtl/mbx_wdt_lock.sv
module mbx_wdt_lock #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slv_rst_i,
  input  logic [CNT_W-1:0] wdt_cnt_i,
  output logic             hit_o,
  output logic             lock_o
);
  logic lock_q;

  assign hit_o = &wdt_cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lock_q <= 1'b0;
    else if (slv_rst_i) lock_q <= 1'b0;
    else if (hit_o)     lock_q <= 1'b1;
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/mbx_fields.sv
module mbx_fields
  import mbx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slv_rst_i,
  input  logic             slv_we_i,
  input  logic [REG_W-1:0] slv_wdata_i,
  input  logic             mst_we_i,
  input  logic [REG_W-1:0] mst_wdata_i,
  input  logic             hit_i,
  input  logic             lock_i,
  output rsp_fields_t      fields_o
);
  rsp_fields_t q, d;
  logic slv_set, mst_clr;

  assign slv_set = slv_we_i & slv_wdata_i[DV_POS];
  assign mst_clr = mst_we_i & ~mst_wdata_i[DV_POS];

  always_comb begin
    d = q;
    if (slv_we_i) d.ien = slv_wdata_i[IEN_POS];
    if (hit_i) begin
      d.stat = '0;
      d.dv   = 1'b1;
    end else begin
      if (slv_we_i && !lock_i) d.stat = slv_wdata_i[STAT_W-1:0];
      // set wins over clear; lock pins the flag
      if (slv_set)                d.dv = 1'b1;
      else if (mst_clr && !lock_i) d.dv = 1'b0;
    end
    if (slv_rst_i) d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign fields_o = q;
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq (
  input  logic ien_i,
  input  logic mreq_dv_i,
  output logic irq_o
);
  assign irq_o = ien_i & mreq_dv_i;
endmodule

// File: rtl/mbx_rsp_reg.sv
module mbx_rsp_reg
  import mbx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slv_rst_i,
  input  logic             slv_we_i,
  input  logic [7:0]       slv_wdata_i,
  output logic [7:0]       slv_rdata_o,
  input  logic             mst_we_i,
  input  logic [7:0]       mst_wdata_i,
  output logic [7:0]       mst_rdata_o,
  input  logic [15:0]      wdt_cnt_i,
  input  logic             mreq_dv_i,
  output logic             req_irq_o
);
  logic        wdt_hit, wdt_lock;
  rsp_fields_t fields;
  logic [REG_W-1:0] rd;

  mbx_wdt_lock #(.CNT_W(CNT_W)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .slv_rst_i(slv_rst_i),
    .wdt_cnt_i(wdt_cnt_i), .hit_o(wdt_hit), .lock_o(wdt_lock)
  );

  mbx_fields u_fields (
    .clk_i(clk_i), .rst_ni(rst_ni), .slv_rst_i(slv_rst_i),
    .slv_we_i(slv_we_i), .slv_wdata_i(slv_wdata_i),
    .mst_we_i(mst_we_i), .mst_wdata_i(mst_wdata_i),
    .hit_i(wdt_hit), .lock_i(wdt_lock), .fields_o(fields)
  );

  mbx_irq u_irq (
    .ien_i(fields.ien), .mreq_dv_i(mreq_dv_i), .irq_o(req_irq_o)
  );

  assign rd          = pack_rsp(fields);
  assign slv_rdata_o = rd;
  assign mst_rdata_o = rd;
endmodule

// File: rtl/mbx_rsp_reg_chk.sv
module mbx_rsp_reg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        slv_rst_i,
  input logic        slv_we_i,
  input logic [7:0]  slv_wdata_i,
  input logic        mst_we_i,
  input logic [7:0]  mst_wdata_i,
  input logic [7:0]  rdata,
  input logic [15:0] wdt_cnt_i,
  input logic        lock,
  input logic        irq
);
  assert_rsvd_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata[7:6] == 2'b00);

  assert_dv_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdata[5]) |-> $past(slv_we_i && slv_wdata_i[5]) || $past(&wdt_cnt_i));

  assert_dv_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdata[5]) |-> $past(mst_we_i && !mst_wdata_i[5]) || $past(slv_rst_i));

  assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slv_we_i && slv_wdata_i[5] && mst_we_i && !mst_wdata_i[5] && !slv_rst_i) |=> rdata[5]);

  assert_wdt_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&wdt_cnt_i && !slv_rst_i) |=> (rdata[3:0] == 4'h0) && rdata[5]);

  assert_lock_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |-> (rdata[3:0] == 4'h0) && rdata[5]);

  assert_slv_rst_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slv_rst_i |=> (rdata == 8'h00) && !lock);

  assert_irq_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata[4] |-> !irq);
endmodule

bind mbx_rsp_reg mbx_rsp_reg_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .slv_rst_i(slv_rst_i),
  .slv_we_i(slv_we_i), .slv_wdata_i(slv_wdata_i),
  .mst_we_i(mst_we_i), .mst_wdata_i(mst_wdata_i),
  .rdata(mst_rdata_o), .wdt_cnt_i(wdt_cnt_i),
  .lock(wdt_lock), .irq(req_irq_o)
);

// File: tb/mbx_rsp_reg_bench.sv
`timescale 1ns/1ps
module mbx_rsp_reg_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        slv_rst_i = 1'b0;
  logic        slv_we_i = 1'b0;
  logic [7:0]  slv_wdata_i = '0;
  logic        mst_we_i = 1'b0;
  logic [7:0]  mst_wdata_i = '0;
  logic [15:0] wdt_cnt_i = '0;
  logic        mreq_dv_i = 1'b0;
  logic [7:0]  slv_rdata_o, mst_rdata_o;
  logic        req_irq_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0]  q_reg[$];
  logic        q_irq[$];
  string       q_tag[$];
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  mbx_rsp_reg u_mbx_rsp_reg (
    .clk_i(clk), .rst_ni(rst_ni), .slv_rst_i(slv_rst_i),
    .slv_we_i(slv_we_i), .slv_wdata_i(slv_wdata_i), .slv_rdata_o(slv_rdata_o),
    .mst_we_i(mst_we_i), .mst_wdata_i(mst_wdata_i), .mst_rdata_o(mst_rdata_o),
    .wdt_cnt_i(wdt_cnt_i), .mreq_dv_i(mreq_dv_i), .req_irq_o(req_irq_o)
  );

  // monitor: compare queued expectations shortly after each edge
  initial begin
    forever begin
      @(posedge clk); #2;
      while (q_reg.size() > 0) begin
        logic [7:0] er; logic ei; string t;
        er = q_reg.pop_front(); ei = q_irq.pop_front(); t = q_tag.pop_front();
        n_chk++;
        if (slv_rdata_o !== er || mst_rdata_o !== er || req_irq_o !== ei) begin
          n_fail++;
          $display("FAIL %s: slv=%h mst=%h irq=%b expected reg=%h irq=%b",
                   t, slv_rdata_o, mst_rdata_o, req_irq_o, er, ei);
        end
      end
    end
  end

  task automatic op(input bit swe, input logic [7:0] sd, input bit mwe,
                    input logic [7:0] md, input logic [15:0] wdt, input bit mreq,
                    input bit srst, input logic [7:0] exp_reg, input bit exp_irq,
                    input string tag);
    @(negedge clk);
    slv_we_i = swe; slv_wdata_i = sd; mst_we_i = mwe; mst_wdata_i = md;
    wdt_cnt_i = wdt; mreq_dv_i = mreq; slv_rst_i = srst;
    @(posedge clk); #1;
    q_reg.push_back(exp_reg); q_irq.push_back(exp_irq); q_tag.push_back(tag);
    @(negedge clk);
    slv_we_i = 1'b0; mst_we_i = 1'b0; slv_rst_i = 1'b0; wdt_cnt_i = '0;
  endtask

  initial begin
    #50000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    q_reg.push_back(8'h00); q_irq.push_back(1'b0); q_tag.push_back("R1 reset");
    @(negedge clk); rst_ni = 1'b1;
    op(1,8'hFF,0,8'h00,16'h0,0,0, 8'h3F,0, "R1 R2 R3 slave write all ones");
    op(0,8'h00,0,8'h00,16'h0,1,0, 8'h3F,1, "R10 irq enabled");
    op(0,8'h00,1,8'hFF,16'h0,1,0, 8'h3F,1, "R4 master write bit5=1 no effect");
    op(0,8'h00,1,8'h00,16'h0,1,0, 8'h1F,1, "R4 master clear");
    op(1,8'h05,0,8'h00,16'h0,1,0, 8'h05,0, "R2 R10 status load, irq masked");
    op(1,8'h20,0,8'h00,16'h0,0,0, 8'h20,0, "R3 slave set");
    op(1,8'h03,0,8'h00,16'h0,0,0, 8'h23,0, "R5 slave cannot clear");
    op(1,8'h27,1,8'h00,16'h0,0,0, 8'h27,0, "R6 set wins");
    op(0,8'h00,1,8'h00,16'h0,0,0, 8'h07,0, "R4 clear after race");
    op(0,8'h00,0,8'h00,16'hFFFE,0,0, 8'h07,0, "R7 no trigger at FFFE");
    op(1,8'h1A,0,8'h00,16'hFFFF,1,0, 8'h30,1, "R7 watchdog load with write");
    op(1,8'h0F,0,8'h00,16'h0,1,0, 8'h20,0, "R8 status locked, ien follows");
    op(0,8'h00,1,8'h00,16'h0,0,0, 8'h20,0, "R8 master clear blocked");
    op(0,8'h00,0,8'h00,16'h0,0,0, 8'h20,0, "R9 lock persists");
    op(1,8'h1F,0,8'h00,16'h0,0,1, 8'h00,0, "R9 slave reset overrides write");
    op(1,8'h09,0,8'h00,16'h0,0,0, 8'h09,0, "R9 lock released");
    op(0,8'h00,0,8'h00,16'hFFFF,0,0, 8'h20,0, "R7 second watchdog event");
    @(negedge clk); rst_ni = 1'b0; #1;
    q_reg.push_back(8'h00); q_irq.push_back(1'b0); q_tag.push_back("R1 async reset");
    @(negedge clk); rst_ni = 1'b1;
    op(1,8'h0C,0,8'h00,16'h0,0,0, 8'h0C,0, "R2 write after global reset");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule